// File: doc/BRIEF.md
# Two-Level Page Walker with 36-Bit Large Pages

The walker turns a 32-bit linear address into a 36-bit physical address by reading a two-level directory structure out of memory. A request gives the linear address, the 4KB-aligned base of the page directory, and two mode bits: a large-page enable and an enable for a separate three-level extended scheme. The walker then issues one memory read at a time through a simple read port and waits as long as needed for each response.

A directory entry either points to a second-level table of 4KB pages, or, when its size bit is set and the large-page path is active, maps a 4MB page directly. The large-page entry is still 32 bits wide, but four otherwise unused entry bits supply physical bits 35:32, so a 4MB page can sit anywhere in a 64GB space. The linear side always stays 32 bits. A missing entry at either level ends the walk with a fault instead of a translation.

The result appears as a one-cycle done strobe with the physical address and a fault flag beside it. A new request is taken only while the walker is idle, which it shows on a ready output.

Top module: `xlat_walker`

## Requirements
- R1: After reset, and whenever reset is asserted mid-walk, `req_ready` is 1 and `mem_rd_valid`, `xl_done` and `xl_fault` are 0.
- R2: The first read of every walk goes to address {dir_base[31:12], lin[31:22], 2'b00}.
- R3: With `req_lpg_en`=1 and `req_ext3_en`=0, a present directory entry (bit 0 = 1) whose size bit (bit 7) is 1 ends the walk after that single read, with physical address {pde[16:13], pde[31:22], lin[21:0]}; entry bits 21:17 have no effect on the result.
- R4: A present directory entry that is not taken as a large page causes a second read at {pde[31:12], lin[21:12], 2'b00}.
- R5: A present second-level entry (bit 0 = 1) gives physical address {4'b0, pte[31:12], lin[11:0]}.
- R6: A directory entry with bit 0 = 0 ends the walk after one read with the fault flag set, whether or not its size bit is set.
- R7: A second-level entry with bit 0 = 0 ends the walk after two reads with the fault flag set.
- R8: With `req_lpg_en`=0, or with `req_ext3_en`=1, the size bit is ignored and every present directory entry is followed as a table pointer, so result bits 35:32 are 0.
- R9: `xl_done` is high for exactly one cycle per walk; `xl_fault` is high only together with `xl_done`, and on a fault `xl_pa` is 0.
- R10: A new request is taken only when `req_ready` is 1; `req_valid` while a walk is in progress has no effect on that walk, and no read is requested while idle.
- R11: A response may come any number of cycles after a read is requested; until it comes, `mem_rd_valid` stays 1 and `mem_rd_addr` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request, taken when `req_ready` is 1 |
| req_lin | input | 32 | Linear address to translate |
| req_dir_base | input | 32 | Page directory base, 4KB aligned |
| req_lpg_en | input | 1 | Large-page enable |
| req_ext3_en | input | 1 | Three-level extended scheme enable (disables the large-page path here) |
| req_ready | output | 1 | Walker idle and able to take a request |
| mem_rd_valid | output | 1 | Read request, held until a response |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid for the outstanding read |
| mem_rsp_data | input | 32 | Entry read from memory |
| xl_done | output | 1 | One-cycle end-of-walk strobe |
| xl_fault | output | 1 | Walk ended on a missing entry |
| xl_pa | output | 36 | Physical address result |

## Verification
The bench builds the walker with its default parameters: a 32-bit linear side, 32-bit entries, a 36-bit physical side, 4KB pages, a 10-bit index per level and the large-page variant generated in. With these values the whole 4MB frame range, including entries whose upper bits put the page above 4GB, and addresses at the very top of the linear space are reachable with a handful of hand-picked entries. The memory model answers after zero to several cycles, so both the same-cycle response and the held-request paths are driven, along with reset in the middle of a walk.

// File: rtl/xw_pkg.sv
package xw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIR  = 2'd1,
    ST_TBL  = 2'd2,
    ST_RESP = 2'd3
  } walk_st_e;

  // entry bit positions that the walk decodes
  localparam int unsigned PRESENT_BIT = 0;
  localparam int unsigned SIZE_BIT    = 7;
  localparam int unsigned EXT_LSB     = 13;

endpackage

// File: rtl/xw_entry_dec.sv
module xw_entry_dec
  import xw_pkg::*;
#(
  parameter int unsigned ENT_W       = 32,
  parameter int unsigned PG_OFF_W    = 12,
  parameter int unsigned LP_OFF_W    = 22,
  parameter int unsigned EXT_W       = 4,
  parameter bit          LARGE_PAGES = 1'b1
) (
  input  logic [ENT_W-1:0]          entry,
  output logic                      present,
  output logic                      is_large,
  output logic [EXT_W-1:0]          ext_bits,
  output logic [ENT_W-LP_OFF_W-1:0] lp_base,
  output logic [ENT_W-PG_OFF_W-1:0] frame
);

  localparam int unsigned FRAME_W = ENT_W - PG_OFF_W;
  localparam int unsigned LPB_W   = ENT_W - LP_OFF_W;

  logic unused_entry_bits;
  assign unused_entry_bits = ^entry;

  assign present = entry[PRESENT_BIT];
  assign frame   = entry[ENT_W-1 -: FRAME_W];

  generate
    if (LARGE_PAGES) begin : g_large
      assign is_large = entry[SIZE_BIT];
      assign ext_bits = entry[EXT_LSB +: EXT_W];
      assign lp_base  = entry[ENT_W-1 -: LPB_W];
    end else begin : g_small_only
      assign is_large = 1'b0;
      assign ext_bits = '0;
      assign lp_base  = '0;
    end
  endgenerate

endmodule

// File: rtl/xw_addr_gen.sv
module xw_addr_gen #(
  parameter int unsigned LIN_W    = 32,
  parameter int unsigned ENT_W    = 32,
  parameter int unsigned PA_W     = 36,
  parameter int unsigned PG_OFF_W = 12,
  parameter int unsigned IDX_W    = 10
) (
  input  logic [LIN_W-1:0]                     lin,
  input  logic [LIN_W-1:0]                     dir_base,
  input  logic [ENT_W-PG_OFF_W-1:0]            pde_frame,
  input  logic                                 tbl_sel,
  input  logic [PA_W-LIN_W-1:0]                ext_bits,
  input  logic [ENT_W-PG_OFF_W-IDX_W-1:0]      lp_base,
  input  logic [ENT_W-PG_OFF_W-1:0]            pte_frame,
  output logic [LIN_W-1:0]                     rd_addr,
  output logic [PA_W-1:0]                      pa_large,
  output logic [PA_W-1:0]                      pa_small
);

  localparam int unsigned LP_OFF_W = PG_OFF_W + IDX_W;
  localparam int unsigned EXT_W    = PA_W - LIN_W;
  localparam int unsigned FRAME_W  = ENT_W - PG_OFF_W;
  localparam int unsigned SLOT_W   = LIN_W - FRAME_W - IDX_W;

  logic [LIN_W-1:0] dir_addr;
  logic [LIN_W-1:0] tbl_addr;
  logic             unused_base_low;

  assign unused_base_low = ^dir_base[PG_OFF_W-1:0];

  assign dir_addr = {dir_base[LIN_W-1:PG_OFF_W], lin[LIN_W-1:LP_OFF_W], {SLOT_W{1'b0}}};
  assign tbl_addr = {pde_frame, lin[LP_OFF_W-1:PG_OFF_W], {SLOT_W{1'b0}}};
  assign rd_addr  = tbl_sel ? tbl_addr : dir_addr;

  assign pa_large = {ext_bits, lp_base, lin[LP_OFF_W-1:0]};
  assign pa_small = {{EXT_W{1'b0}}, pte_frame, lin[PG_OFF_W-1:0]};

endmodule

// File: rtl/xw_ctrl.sv
module xw_ctrl
  import xw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  logic     mem_rsp_valid,
  input  logic     ent_present,
  input  logic     ent_large,
  input  logic     large_mode,
  output walk_st_e state_q,
  output logic     req_take,
  output logic     pde_take,
  output logic     res_take,
  output logic     res_fault,
  output logic     res_large
);

  walk_st_e state_d;

  always_comb begin
    state_d   = state_q;
    req_take  = 1'b0;
    pde_take  = 1'b0;
    res_take  = 1'b0;
    res_fault = 1'b0;
    res_large = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          req_take = 1'b1;
          state_d  = ST_DIR;
        end
      end
      ST_DIR: begin
        if (mem_rsp_valid) begin
          if (!ent_present) begin
            res_take  = 1'b1;
            res_fault = 1'b1;
            state_d   = ST_RESP;
          end else if (large_mode && ent_large) begin
            res_take  = 1'b1;
            res_large = 1'b1;
            state_d   = ST_RESP;
          end else begin
            pde_take = 1'b1;
            state_d  = ST_TBL;
          end
        end
      end
      ST_TBL: begin
        if (mem_rsp_valid) begin
          res_take  = 1'b1;
          res_fault = !ent_present;
          state_d   = ST_RESP;
        end
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R9: the end-of-walk state lasts one cycle
  p_resp_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RESP) |=> (state_q == ST_IDLE));

  // R11: a walk state is left only on a response
  p_wait_for_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_DIR || state_q == ST_TBL) && !mem_rsp_valid) |=> $stable(state_q));

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xw_pkg::*;
#(
  parameter int unsigned LIN_W       = 32,
  parameter int unsigned ENT_W       = 32,
  parameter int unsigned PA_W        = 36,
  parameter int unsigned PG_OFF_W    = 12,
  parameter int unsigned IDX_W       = 10,
  parameter bit          LARGE_PAGES = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LIN_W-1:0] req_lin,
  input  logic [LIN_W-1:0] req_dir_base,
  input  logic             req_lpg_en,
  input  logic             req_ext3_en,
  output logic             req_ready,
  output logic             mem_rd_valid,
  output logic [LIN_W-1:0] mem_rd_addr,
  input  logic             mem_rsp_valid,
  input  logic [ENT_W-1:0] mem_rsp_data,
  output logic             xl_done,
  output logic             xl_fault,
  output logic [PA_W-1:0]  xl_pa
);

  localparam int unsigned LP_OFF_W = PG_OFF_W + IDX_W;
  localparam int unsigned EXT_W    = PA_W - LIN_W;
  localparam int unsigned FRAME_W  = ENT_W - PG_OFF_W;
  localparam int unsigned LPB_W    = ENT_W - LP_OFF_W;

  walk_st_e state_q;
  logic     req_take, pde_take, res_take, res_fault, res_large;

  logic [LIN_W-1:0]   lin_q;
  logic [LIN_W-1:0]   base_q;
  logic               large_mode_q;
  logic [FRAME_W-1:0] pde_frame_q;
  logic [PA_W-1:0]    pa_q;
  logic               fault_q;

  logic               ent_present, ent_large;
  logic [EXT_W-1:0]   ent_ext;
  logic [LPB_W-1:0]   ent_lp_base;
  logic [FRAME_W-1:0] ent_frame;
  logic [PA_W-1:0]    pa_large, pa_small, pa_d;

  xw_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .mem_rsp_valid (mem_rsp_valid),
    .ent_present   (ent_present),
    .ent_large     (ent_large),
    .large_mode    (large_mode_q),
    .state_q       (state_q),
    .req_take      (req_take),
    .pde_take      (pde_take),
    .res_take      (res_take),
    .res_fault     (res_fault),
    .res_large     (res_large)
  );

  xw_entry_dec #(
    .ENT_W       (ENT_W),
    .PG_OFF_W    (PG_OFF_W),
    .LP_OFF_W    (LP_OFF_W),
    .EXT_W       (EXT_W),
    .LARGE_PAGES (LARGE_PAGES)
  ) u_dec (
    .entry    (mem_rsp_data),
    .present  (ent_present),
    .is_large (ent_large),
    .ext_bits (ent_ext),
    .lp_base  (ent_lp_base),
    .frame    (ent_frame)
  );

  xw_addr_gen #(
    .LIN_W    (LIN_W),
    .ENT_W    (ENT_W),
    .PA_W     (PA_W),
    .PG_OFF_W (PG_OFF_W),
    .IDX_W    (IDX_W)
  ) u_agen (
    .lin       (lin_q),
    .dir_base  (base_q),
    .pde_frame (pde_frame_q),
    .tbl_sel   (state_q == ST_TBL),
    .ext_bits  (ent_ext),
    .lp_base   (ent_lp_base),
    .pte_frame (ent_frame),
    .rd_addr   (mem_rd_addr),
    .pa_large  (pa_large),
    .pa_small  (pa_small)
  );

  // request capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin_q        <= '0;
      base_q       <= '0;
      large_mode_q <= 1'b0;
    end else if (req_take) begin
      lin_q        <= req_lin;
      base_q       <= req_dir_base;
      large_mode_q <= req_lpg_en && !req_ext3_en;
    end
  end

  // directory entry frame for the second read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pde_frame_q <= '0;
    else if (pde_take) pde_frame_q <= ent_frame;
  end

  // result
  always_comb begin
    if (res_fault)      pa_d = '0;
    else if (res_large) pa_d = pa_large;
    else                pa_d = pa_small;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q    <= '0;
      fault_q <= 1'b0;
    end else if (res_take) begin
      pa_q    <= pa_d;
      fault_q <= res_fault;
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign mem_rd_valid = (state_q == ST_DIR) || (state_q == ST_TBL);
  assign xl_done      = (state_q == ST_RESP);
  assign xl_fault     = xl_done && fault_q;
  assign xl_pa        = xl_done ? pa_q : '0;

  // R11: an outstanding read keeps its address until answered
  p_addr_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rsp_valid) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  // R9: done is a single-cycle strobe
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xl_done |=> !xl_done);

  // R9: fault only with done, and a faulted result carries no address
  p_fault_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xl_fault |-> (xl_done && xl_pa == '0));

  // R10: no read while idle
  p_idle_no_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd_valid);

  // R8: without the large-page path the result stays below 4GB
  p_small_below_4g_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_done && !large_mode_q) |-> (xl_pa[PA_W-1:LIN_W] == '0));

  // R2: a walk always begins with the directory read
  p_dir_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid) |=> (mem_rd_valid &&
      mem_rd_addr[LIN_W-1:PG_OFF_W] == {$past(req_dir_base[LIN_W-1:LP_OFF_W]),
                                        $past(req_dir_base[LP_OFF_W-1:PG_OFF_W])}));

endmodule

// File: tb/xlat_walker_bench.sv
`timescale 1ns/1ps
module xlat_walker_bench;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_lin;
  logic [31:0] req_dir_base;
  logic        req_lpg_en;
  logic        req_ext3_en;
  logic        req_ready;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        xl_done;
  logic        xl_fault;
  logic [35:0] xl_pa;

  xlat_walker u_xlat_walker (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_lin       (req_lin),
    .req_dir_base  (req_dir_base),
    .req_lpg_en    (req_lpg_en),
    .req_ext3_en   (req_ext3_en),
    .req_ready     (req_ready),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .xl_done       (xl_done),
    .xl_fault      (xl_fault),
    .xl_pa         (xl_pa)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model: answers each read after mem_lat extra cycles
  logic [31:0] mem_pde, mem_pte;
  int          mem_lat;
  int          n_rd;
  logic [31:0] rd_addr_log [2];
  logic [31:0] hold_addr;
  int          waitc;
  bit          addr_moved;

  initial begin
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    waitc = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (!mem_rd_valid) begin
        waitc = 0;
      end else begin
        if (waitc == 0) hold_addr = mem_rd_addr;
        else if (mem_rd_addr != hold_addr) addr_moved = 1'b1;
        if (waitc >= mem_lat) begin
          if (n_rd < 2) rd_addr_log[n_rd] = mem_rd_addr;
          mem_rsp_data  = (n_rd == 0) ? mem_pde : mem_pte;
          mem_rsp_valid = 1'b1;
          n_rd++;
          waitc = 0;
        end else begin
          waitc++;
        end
      end
    end
  end

  typedef struct packed {
    logic [3:0]  req;
    logic [31:0] lin;
    logic [31:0] base;
    logic        lpg;
    logic        ext;
    logic [31:0] pde;
    logic [31:0] pte;
    logic [31:0] a1;
    logic [31:0] a2;
    logic [35:0] pa;
    logic        flt;
    logic [1:0]  nrd;
    logic [1:0]  lat;
  } vec_t;

  localparam int NV = 9;
  // req tags: R3 large page, R8 size bit ignored, R5 small page, R6/R7 faults
  localparam vec_t VECS [NV] = '{
    '{4'd3, 32'h1234_5678, 32'h0010_0000, 1'b1, 1'b0, 32'hFFD1_4081, 32'h0,
      32'h0010_0120, 32'h0, 36'hA_FFF4_5678, 1'b0, 2'd1, 2'd2},
    '{4'd8, 32'h1234_5678, 32'h0010_0000, 1'b0, 1'b0, 32'hFFD1_4081, 32'h0ABC_D003,
      32'h0010_0120, 32'hFFD1_4D14, 36'h0_0ABC_D678, 1'b0, 2'd2, 2'd0},
    '{4'd8, 32'h1234_5678, 32'h0010_0000, 1'b1, 1'b1, 32'hFFD1_4081, 32'h0ABC_D003,
      32'h0010_0120, 32'hFFD1_4D14, 36'h0_0ABC_D678, 1'b0, 2'd2, 2'd1},
    '{4'd5, 32'hFFFF_FFFF, 32'hFFFF_F000, 1'b1, 1'b0, 32'h0000_2001, 32'hFFFF_F001,
      32'hFFFF_FFFC, 32'h0000_2FFC, 36'h0_FFFF_FFFF, 1'b0, 2'd2, 2'd3},
    '{4'd6, 32'h0000_0000, 32'h0000_1000, 1'b1, 1'b0, 32'hFFD1_4080, 32'h0,
      32'h0000_1000, 32'h0, 36'h0, 1'b1, 2'd1, 2'd0},
    '{4'd6, 32'h0000_0000, 32'h0000_1000, 1'b0, 1'b0, 32'h0000_3000, 32'h0,
      32'h0000_1000, 32'h0, 36'h0, 1'b1, 2'd1, 2'd1},
    '{4'd7, 32'h0040_1ABC, 32'h0000_2000, 1'b0, 1'b0, 32'h0000_5001, 32'h1234_5FFE,
      32'h0000_2004, 32'h0000_5004, 36'h0, 1'b1, 2'd2, 2'd2},
    '{4'd3, 32'h0040_1ABC, 32'h0000_2000, 1'b1, 1'b0, 32'h00C0_0083, 32'h0,
      32'h0000_2004, 32'h0, 36'h0_00C0_1ABC, 1'b0, 2'd1, 2'd0},
    '{4'd3, 32'h0040_1ABC, 32'h0000_2000, 1'b1, 1'b0, 32'h003F_E081, 32'h0,
      32'h0000_2004, 32'h0, 36'hF_0000_1ABC, 1'b0, 2'd1, 2'd1}
  };

  task automatic start_walk(input vec_t v);
    mem_pde = v.pde; mem_pte = v.pte; mem_lat = int'(v.lat);
    n_rd = 0; addr_moved = 1'b0;
    rd_addr_log[0] = '0; rd_addr_log[1] = '0;
    while (!req_ready) @(negedge clk);
    req_lin = v.lin; req_dir_base = v.base;
    req_lpg_en = v.lpg; req_ext3_en = v.ext;
    req_valid = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_walk(input vec_t v, input string tag);
    while (!xl_done) @(negedge clk);
    check(xl_pa == v.pa, tag, "physical address", xl_pa, v.pa);
    check(xl_fault == v.flt, tag, "fault flag", 36'(xl_fault), 36'(v.flt));
    check(n_rd == int'(v.nrd), tag, "read count", 36'(n_rd), 36'(v.nrd));
    check(rd_addr_log[0] == v.a1, "R2", "directory read address",
          36'(rd_addr_log[0]), 36'(v.a1));
    if (v.nrd == 2'd2)
      check(rd_addr_log[1] == v.a2, "R4", "table read address",
            36'(rd_addr_log[1]), 36'(v.a2));
    check(!addr_moved, "R11", "address held while waiting", 36'(addr_moved), 36'(0));
    req_valid = 1'b0;
    @(negedge clk);
    check(!xl_done && req_ready, "R9", "done lasts one cycle",
          36'({xl_done, req_ready}), 36'(1));
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_lin = '0; req_dir_base = '0;
    req_lpg_en = 1'b0; req_ext3_en = 1'b0;
    mem_pde = '0; mem_pte = '0; mem_lat = 0; n_rd = 0;
    addr_moved = 1'b0; hold_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(req_ready && !mem_rd_valid && !xl_done && !xl_fault, "R1", "reset state",
          36'({req_ready, mem_rd_valid, xl_done, xl_fault}), 36'(4'b1000));

    // table walk
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tag;
      v = VECS[i];
      tag = $sformatf("R%0d", v.req);
      start_walk(v);
      req_valid = 1'b0;
      finish_walk(v, tag);
    end

    // R10: request held high with other values during a walk has no effect
    begin
      vec_t v;
      v = VECS[3];
      start_walk(v);
      check(!req_ready, "R10", "busy during walk", 36'(req_ready), 36'(0));
      req_lin = 32'h0000_0000; req_dir_base = 32'h0000_7000;
      req_lpg_en = 1'b0;
      finish_walk(v, "R10");
    end

    // R1: reset in the middle of a walk returns to idle
    begin
      vec_t v;
      v = VECS[0];
      v.lat = 2'd3;
      start_walk(v);
      req_valid = 1'b0;
      rst_n = 1'b0;
      #1;
      check(req_ready && !mem_rd_valid && !xl_done && !xl_fault, "R1",
            "reset mid-walk", 36'({req_ready, mem_rd_valid, xl_done, xl_fault}),
            36'(4'b1000));
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!mem_rd_valid && !xl_done, "R10", "idle after reset, no read",
            36'({mem_rd_valid, xl_done}), 36'(0));
      // a normal walk afterwards still works
      start_walk(VECS[7]);
      req_valid = 1'b0;
      finish_walk(VECS[7], "R3");
    end

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule